// File: doc/BRIEF.md
# Bidirectional FIFO Port Controller with Mailbox

This block is the control logic for one side of a pair of FIFOs that carry data in opposite directions. A single shared bus is used for both directions. One direction input picks whether a port cycle writes a word toward the far side or reads a word arriving from it. A mailbox-select input sends the transfer to a one-word mailbox register instead of the FIFO. The block decodes chip select, direction, enable and mailbox select on each rising port clock. From that decode it produces registered strobes for the outbound FIFO write, the inbound FIFO read, the mailbox write and the mailbox read. It also drives the select for the data output mux and the enable for the output tri-state driver.

Both mailbox registers live here, each with an active-low full flag. The outgoing mailbox is loaded from this port and emptied by a read from the far port. The incoming mailbox is loaded by the far port and emptied by a mailbox read on this port. The FIFO arrays and their flag logic are outside the block. Back-pressure works as follows:
- `in_ready` acts as the ready of the outbound FIFO. A write decoded while it is low is dropped, and the host must repeat it.
- `out_ready` acts as the valid of the inbound FIFO. A read decoded while it is low produces no strobe.
- The mailbox full flags give back-pressure for mailbox traffic.

The parameter `WRITE_LEVEL` sets which level of `wr_rd` selects a write. This lets the two ports of a pair use opposite direction senses.

Top module: `bififo_port_ctrl`

## Requirements
- R1: `dout_oe` is 1 exactly when `cs_n` is 0 and `wr_rd` is not equal to `WRITE_LEVEL` (the read direction); otherwise it is 0.
- R2: `dout_sel` equals `mbox_sel` (0 = FIFO output word, 1 = incoming mailbox), and `dout` shows `fifo_q` or the incoming mailbox word accordingly, whatever the level of `en`.
- R3: A rising edge with `cs_n`=0, write direction, `en`=1, `mbox_sel`=0 and `in_ready`=1 makes `fifo_wr` high for the following cycle only, with `fifo_wdata` equal to `din` sampled at that edge; with `in_ready`=0 no strobe appears.
- R4: A rising edge with `cs_n`=0, read direction, `en`=1, `mbox_sel`=0 and `out_ready`=1 makes `fifo_rd` high for the following cycle; with `out_ready`=0 no strobe appears.
- R5: An edge with `en`=0 produces no strobe and leaves both mailboxes and their flags unchanged.
- R6: A mailbox write (`cs_n`=0, write direction, `en`=1, `mbox_sel`=1) while `mbox_out_full_n`=1 loads `din` into `mbox_out_data`, drives `mbox_out_full_n` to 0 and pulses `mbox_wr` for one cycle.
- R7: A mailbox write while `mbox_out_full_n`=0 is ignored: the data is unchanged and `mbox_wr` stays 0.
- R8: `mbox_out_rd` high at an edge while `mbox_out_full_n`=0 returns `mbox_out_full_n` to 1.
- R9: `mbox_in_wr` high at an edge while `mbox_in_full_n`=1 loads `mbox_in_data` and drives `mbox_in_full_n` to 0; while the flag is 0 the far-side write is ignored.
- R10: A mailbox read (`cs_n`=0, read direction, `en`=1, `mbox_sel`=1) pulses `mbox_rd` for one cycle and sets `mbox_in_full_n` to 1.
- R11: While `rst_n` is 0, all strobes are 0, both full flags are 1 and both mailbox words are 0.
- R12: With `WRITE_LEVEL`=1, `wr_rd`=1 selects a FIFO write and disables the output driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cs_n | input | 1 | Active-low chip select |
| wr_rd | input | 1 | Direction select; level `WRITE_LEVEL` means write |
| en | input | 1 | Transfer enable |
| mbox_sel | input | 1 | 1 routes the transfer to a mailbox |
| in_ready | input | 1 | Outbound FIFO can accept a word |
| out_ready | input | 1 | Inbound FIFO has a word in its output register |
| din | input | DW | Write data from the bus |
| fifo_q | input | DW | Inbound FIFO output register |
| mbox_in_wr | input | 1 | Far port writes the incoming mailbox |
| mbox_in_data | input | DW | Far port mailbox data |
| mbox_out_rd | input | 1 | Far port reads the outgoing mailbox |
| fifo_wr | output | 1 | Outbound FIFO write strobe |
| fifo_wdata | output | DW | Registered write word |
| fifo_rd | output | 1 | Inbound FIFO read strobe |
| mbox_wr | output | 1 | Accepted mailbox write strobe |
| mbox_rd | output | 1 | Mailbox read strobe |
| dout_sel | output | 1 | Output mux select (1 = mailbox) |
| dout_oe | output | 1 | Output driver enable |
| dout | output | DW | Muxed read data |
| mbox_out_data | output | DW | Outgoing mailbox word |
| mbox_out_full_n | output | 1 | Outgoing mailbox full, active low |
| mbox_in_full_n | output | 1 | Incoming mailbox full, active low |

## Verification
The assertions assume that the far port raises `mbox_out_rd` only as a single-cycle request. They also assume that the ready flags and the control inputs are synchronous to `clk` and stable around its rising edge. The bench changes every input at the falling edge and pulses far-side requests for exactly one cycle. It never drives `mbox_out_rd` or `mbox_in_wr` in the same cycle as a local mailbox operation, which keeps each mailbox's priority rule out of the stimulus.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_FIFO_WR = 3'd1,
    OP_FIFO_RD = 3'd2,
    OP_MBOX_WR = 3'd3,
    OP_MBOX_RD = 3'd4
  } port_op_e;
endpackage

// File: rtl/bfp_decode.sv
module bfp_decode
  import bfp_pkg::*;
#(
  parameter bit WRITE_LEVEL = 1'b0
) (
  input  logic     cs_n,
  input  logic     wr_rd,
  input  logic     en,
  input  logic     mbox_sel,
  output port_op_e op,
  output logic     oe,
  output logic     sel
);
  logic is_write;

  always_comb begin
    is_write = (wr_rd == WRITE_LEVEL);
    oe       = !cs_n && !is_write;
    sel      = mbox_sel;
    op       = OP_IDLE;
    if (!cs_n && en) begin
      unique case ({is_write, mbox_sel})
        2'b10:   op = OP_FIFO_WR;
        2'b11:   op = OP_MBOX_WR;
        2'b00:   op = OP_FIFO_RD;
        default: op = OP_MBOX_RD;
      endcase
    end
  end
endmodule

// File: rtl/bfp_mailbox.sv
module bfp_mailbox #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_req,
  input  logic [DW-1:0] load_data,
  input  logic          take,
  output logic          load_ok,
  output logic [DW-1:0] q,
  output logic          full_n
);
  assign load_ok = load_req && full_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      full_n <= 1'b1;
    end else if (load_ok) begin
      q      <= load_data;
      full_n <= 1'b0;
    end else if (!full_n && take) begin
      full_n <= 1'b1;
    end
  end
endmodule

// File: rtl/bififo_port_ctrl.sv
module bififo_port_ctrl
  import bfp_pkg::*;
#(
  parameter int DW          = 32,
  parameter bit WRITE_LEVEL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_rd,
  input  logic          en,
  input  logic          mbox_sel,
  input  logic          in_ready,
  input  logic          out_ready,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] fifo_q,
  input  logic          mbox_in_wr,
  input  logic [DW-1:0] mbox_in_data,
  input  logic          mbox_out_rd,
  output logic          fifo_wr,
  output logic [DW-1:0] fifo_wdata,
  output logic          fifo_rd,
  output logic          mbox_wr,
  output logic          mbox_rd,
  output logic          dout_sel,
  output logic          dout_oe,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] mbox_out_data,
  output logic          mbox_out_full_n,
  output logic          mbox_in_full_n
);
  port_op_e      op;
  logic          out_load_ok;
  logic          in_load_ok;
  logic [DW-1:0] mbox_in_q;

  bfp_decode #(.WRITE_LEVEL(WRITE_LEVEL)) u_decode (
    .cs_n     (cs_n),
    .wr_rd    (wr_rd),
    .en       (en),
    .mbox_sel (mbox_sel),
    .op       (op),
    .oe       (dout_oe),
    .sel      (dout_sel)
  );

  // Outgoing mailbox: loaded here, drained by the far port.
  bfp_mailbox #(.DW(DW)) u_mbox_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (op == OP_MBOX_WR),
    .load_data (din),
    .take      (mbox_out_rd),
    .load_ok   (out_load_ok),
    .q         (mbox_out_data),
    .full_n    (mbox_out_full_n)
  );

  // Incoming mailbox: loaded by the far port, drained here.
  bfp_mailbox #(.DW(DW)) u_mbox_in (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (mbox_in_wr),
    .load_data (mbox_in_data),
    .take      (op == OP_MBOX_RD),
    .load_ok   (in_load_ok),
    .q         (mbox_in_q),
    .full_n    (mbox_in_full_n)
  );

  assign dout = dout_sel ? mbox_in_q : fifo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr    <= 1'b0;
      fifo_rd    <= 1'b0;
      mbox_wr    <= 1'b0;
      mbox_rd    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      fifo_wr <= (op == OP_FIFO_WR) && in_ready;
      fifo_rd <= (op == OP_FIFO_RD) && out_ready;
      mbox_wr <= out_load_ok;
      mbox_rd <= (op == OP_MBOX_RD);
      if ((op == OP_FIFO_WR) && in_ready) fifo_wdata <= din;
    end
  end

  logic unused_in_load_ok;
  assign unused_in_load_ok = in_load_ok;
endmodule

// File: rtl/bfp_port_chk.sv
module bfp_port_chk #(
  parameter int DW          = 32,
  parameter bit WRITE_LEVEL = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          wr_rd,
  input logic          en,
  input logic          mbox_sel,
  input logic          in_ready,
  input logic          out_ready,
  input logic          mbox_out_rd,
  input logic          fifo_wr,
  input logic          fifo_rd,
  input logic          mbox_wr,
  input logic          mbox_rd,
  input logic          dout_oe,
  input logic [DW-1:0] mbox_out_data,
  input logic          mbox_out_full_n,
  input logic          mbox_in_full_n
);
  // R1: a deselected port never drives the bus
  a_r1_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !dout_oe);

  // R2: at most one strobe per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_wr, fifo_rd, mbox_wr, mbox_rd}));

  // R3
  a_r3_fifo_wr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(!cs_n && en && !mbox_sel && in_ready && (wr_rd == WRITE_LEVEL)));

  // R4
  a_r4_fifo_rd_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> $past(!cs_n && en && !mbox_sel && out_ready && (wr_rd != WRITE_LEVEL)));

  // R5
  a_r5_en_low_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(fifo_wr || fifo_rd || mbox_wr || mbox_rd));

  // R6
  a_r6_mbox_wr_full: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_wr |-> !mbox_out_full_n);

  // R7
  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!mbox_out_full_n && !mbox_out_rd) |=> ($stable(mbox_out_data) && !mbox_wr));

  // R8
  a_r8_far_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!mbox_out_full_n && mbox_out_rd) |=> mbox_out_full_n);

  // R10
  a_r10_local_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && en && mbox_sel && (wr_rd != WRITE_LEVEL) && !mbox_in_full_n)
      |=> (mbox_in_full_n && mbox_rd));
endmodule

bind bififo_port_ctrl bfp_port_chk #(.DW(DW), .WRITE_LEVEL(WRITE_LEVEL)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cs_n            (cs_n),
  .wr_rd           (wr_rd),
  .en              (en),
  .mbox_sel        (mbox_sel),
  .in_ready        (in_ready),
  .out_ready       (out_ready),
  .mbox_out_rd     (mbox_out_rd),
  .fifo_wr         (fifo_wr),
  .fifo_rd         (fifo_rd),
  .mbox_wr         (mbox_wr),
  .mbox_rd         (mbox_rd),
  .dout_oe         (dout_oe),
  .mbox_out_data   (mbox_out_data),
  .mbox_out_full_n (mbox_out_full_n),
  .mbox_in_full_n  (mbox_in_full_n)
);

// File: tb/test_bififo_port_ctrl.sv
`timescale 1ns/1ps
module test_bififo_port_ctrl;
  localparam int DW = 32;
  localparam logic [DW-1:0] FQ = 32'h1111_2222;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_rd = 1'b0, en = 1'b0, mbox_sel = 1'b0;
  logic in_ready = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] din = '0, mbox_in_data = '0;
  logic mbox_in_wr = 1'b0, mbox_out_rd = 1'b0;

  logic fifo_wr, fifo_rd, mbox_wr, mbox_rd, dout_sel, dout_oe;
  logic mbox_out_full_n, mbox_in_full_n;
  logic [DW-1:0] fifo_wdata, dout, mbox_out_data;

  logic v_fifo_wr, v_fifo_rd, v_mbox_wr, v_mbox_rd, v_sel, v_oe, v_ofn, v_ifn;
  logic [DW-1:0] v_wdata, v_dout, v_odata;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bififo_port_ctrl #(.DW(DW)) i_bififo_port_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wr_rd), .en(en), .mbox_sel(mbox_sel),
    .in_ready(in_ready), .out_ready(out_ready), .din(din), .fifo_q(FQ),
    .mbox_in_wr(mbox_in_wr), .mbox_in_data(mbox_in_data), .mbox_out_rd(mbox_out_rd),
    .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .fifo_rd(fifo_rd), .mbox_wr(mbox_wr),
    .mbox_rd(mbox_rd), .dout_sel(dout_sel), .dout_oe(dout_oe), .dout(dout),
    .mbox_out_data(mbox_out_data), .mbox_out_full_n(mbox_out_full_n),
    .mbox_in_full_n(mbox_in_full_n));

  bififo_port_ctrl #(.DW(DW), .WRITE_LEVEL(1'b1)) i_bififo_port_ctrl_inv (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_rd(wr_rd), .en(en), .mbox_sel(mbox_sel),
    .in_ready(in_ready), .out_ready(out_ready), .din(din), .fifo_q(FQ),
    .mbox_in_wr(1'b0), .mbox_in_data(mbox_in_data), .mbox_out_rd(1'b0),
    .fifo_wr(v_fifo_wr), .fifo_wdata(v_wdata), .fifo_rd(v_fifo_rd), .mbox_wr(v_mbox_wr),
    .mbox_rd(v_mbox_rd), .dout_sel(v_sel), .dout_oe(v_oe), .dout(v_dout),
    .mbox_out_data(v_odata), .mbox_out_full_n(v_ofn), .mbox_in_full_n(v_ifn));

  // {cs_n, wr_rd, en, mbox_sel, in_ready, out_ready, exp fifo_wr, exp fifo_rd, exp oe, exp sel}
  localparam int NV = 10;
  localparam logic [9:0] VEC [NV] = '{
    10'b1_0_1_0_1_1_0_0_0_0,
    10'b0_0_1_0_1_1_1_0_0_0,
    10'b0_0_1_0_0_1_0_0_0_0,
    10'b0_1_1_0_1_1_0_1_1_0,
    10'b0_1_1_0_1_0_0_0_1_0,
    10'b0_1_0_0_1_1_0_0_1_0,
    10'b0_1_0_1_1_1_0_0_1_1,
    10'b0_0_0_0_1_1_0_0_0_0,
    10'b1_1_1_0_1_1_0_0_0_0,
    10'b0_0_1_0_1_0_1_0_0_0
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic e, input logic m);
    @(negedge clk);
    cs_n = c; wr_rd = w; en = e; mbox_sel = m;
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset state
    #12;
    chk("R11 fifo_wr", fifo_wr, 0);
    chk("R11 mbox_out_full_n", mbox_out_full_n, 1);
    chk("R11 mbox_in_full_n", mbox_in_full_n, 1);
    chk("R11 mbox_out_data", mbox_out_data, 0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cs_n, wr_rd, en, mbox_sel, in_ready, out_ready} = VEC[i][9:4];
      din = 32'hA000_0000 + i;
      #1;
      chk("R1 oe", dout_oe, VEC[i][1]);
      chk("R2 sel", dout_sel, VEC[i][0]);
      chk("R2 dout", dout, VEC[i][0] ? 32'h0 : FQ);
      after_edge();
      chk("R3 fifo_wr", fifo_wr, VEC[i][3]);
      chk("R4 fifo_rd", fifo_rd, VEC[i][2]);
      chk("R5 no mbox strobe", {mbox_wr, mbox_rd}, 2'b00);
      if (VEC[i][3]) chk("R3 fifo_wdata", fifo_wdata, 32'hA000_0000 + i);
    end

    // R3: strobe lasts one cycle
    drive(1, 0, 0, 0);
    after_edge();
    chk("R3 strobe drops", fifo_wr, 0);

    // R5: mailbox write with enable low is ignored
    din = 32'h0BAD_0BAD;
    drive(0, 0, 0, 1);
    after_edge();
    chk("R5 full_n kept", mbox_out_full_n, 1);
    chk("R5 data kept", mbox_out_data, 0);

    // R6: mailbox write
    din = 32'hDEAD_0001;
    drive(0, 0, 1, 1);
    after_edge();
    chk("R6 mbox_wr", mbox_wr, 1);
    chk("R6 full_n", mbox_out_full_n, 0);
    chk("R6 data", mbox_out_data, 32'hDEAD_0001);

    // R7: write while full ignored
    din = 32'hBEEF_0002;
    after_edge();
    chk("R7 no strobe", mbox_wr, 0);
    chk("R7 data kept", mbox_out_data, 32'hDEAD_0001);

    // R8: far read empties
    drive(1, 0, 0, 0);
    mbox_out_rd = 1'b1;
    after_edge();
    chk("R8 full_n", mbox_out_full_n, 1);
    @(negedge clk); mbox_out_rd = 1'b0;

    // R9: far write into incoming mailbox
    mbox_in_data = 32'h5555_0055; mbox_in_wr = 1'b1;
    after_edge();
    chk("R9 full_n", mbox_in_full_n, 0);
    @(negedge clk); mbox_in_data = 32'h6666_0066;
    after_edge();
    @(negedge clk); mbox_in_wr = 1'b0;
    cs_n = 0; wr_rd = 1; en = 0; mbox_sel = 1;
    #1;
    chk("R9 ignored when full", dout, 32'h5555_0055);
    chk("R2 oe with en low", dout_oe, 1);

    // R10: local mailbox read
    drive(0, 1, 1, 1);
    after_edge();
    chk("R10 mbox_rd", mbox_rd, 1);
    chk("R10 full_n", mbox_in_full_n, 1);
    drive(1, 0, 0, 0);
    after_edge();
    chk("R10 strobe drops", mbox_rd, 0);

    // R12: inverted direction sense
    in_ready = 1; out_ready = 1;
    drive(0, 1, 1, 0);
    #1;
    chk("R12 inv oe", v_oe, 0);
    after_edge();
    chk("R12 inv fifo_wr", v_fifo_wr, 1);
    chk("R12 main reads", fifo_rd, 1);

    // R11: reset mid-run clears mailbox
    drive(0, 0, 1, 1);
    after_edge();
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R11 reset full_n", mbox_out_full_n, 1);
    chk("R11 reset strobe", mbox_wr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule